// File: doc/BRIEF.md
# Interprocessor Mailbox

This block lets several processors trade 32-bit messages through a small register window. It contains a parameter-set number of independent message queues and a parameter-set number of users. Any processor can push a word by writing a queue's message register and pop the oldest word by reading it. Each queue also exposes how many words it holds and whether it is full.

Every user has its own interrupt status register and its own enable mask, and drives one interrupt line. Two events per queue feed the status registers: one means a message is waiting and one means the queue is no longer full. A parameter picks one of two register layouts. The legacy layout has a single read/write enable register per user. The split layout has separate enable-set and enable-clear registers.

The register bus has no back-pressure. An access is taken in the cycle it is strobed. A read returns its data one cycle later, marked by `rd_valid`, and the requester must take it in that cycle. A cycle with both `bus_wr` and `bus_rd` high counts as a write, and the read strobe is ignored.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, all status and enable bits are 0, every `irq` line is low, and offset 0x000 reads the revision byte: major version in bits [7:4] and minor version in bits [3:0] (default 0x21).
- R2: Writing offset 0x040+4*m pushes the word into queue m. Reading that offset pops the oldest word in FIFO order. The read data appears on `rd_data` with `rd_valid` high in the cycle after the strobe.
- R3: Offset 0x0C0+4*m reads the number of words held in queue m, which is 0 exactly when the queue is empty.
- R4: Offset 0x080+4*m reads 1 when queue m holds DEPTH words (default 4) and 0 otherwise.
- R5: A write to a full queue is dropped. The count stays at DEPTH and the stored words are unchanged.
- R6: A read of an empty queue returns 0 and leaves its count at 0.
- R7: Status bit 2*m is the new-message event of queue m. It is set in the cycle after any cycle in which queue m is non-empty and the bit is not being cleared, so it sets again right after a clear when words remain.
- R8: Status bit 2*m+1 is the not-full event of queue m. It is set by the edge of a pop that takes queue m from full to not full.
- R9: Status registers are write-one-to-clear. A 1 bit clears, a 0 bit leaves the bit unchanged, and a read in the very next cycle returns the cleared value.
- R10: In the legacy layout, user u's status register is at 0x100+8*u and its enable register is at 0x104+8*u. A write replaces the whole mask and a read returns it.
- R11: In the split layout, user u's status register is at 0x104+0x10*u. Writing 1 bits at 0x108+0x10*u enables those bits, and writing 1 bits at 0x10C+0x10*u disables them. Zero bits have no effect, and both offsets read back the mask.
- R12: `irq[u]` is high exactly when user u's status AND its enable mask is nonzero.
- R13: Unmapped offsets read 0, and writes to them change nothing. This includes the legacy status offsets when the split layout is selected.
- R14: Each user has its own status and enable registers. Clearing or enabling bits for one user does not affect another user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, ignored while `bus_wr` is high |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High in the cycle after an accepted read |
| irq | output | NU (2) | One interrupt line per user |

## Verification
Two functions can land on the same edge. A write-one-to-clear of a user's new-message bit can arrive while the queue behind that bit is still non-empty, so the clear and the event that sets the bit meet on one edge. The bench provokes this by clearing the bit while words remain and reading the status register in the next two cycles: the first read must show 0, and the second must show the bit set again. The interrupt line is checked between those two reads. In the same way, a pop that drains a full queue sets the not-full bit on the same edge that returns the data, and the interrupt line is sampled right after that pop.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    LAYOUT_LEGACY = 1'b0,
    LAYOUT_SPLIT  = 1'b1
  } mbx_layout_e;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          nf_pulse
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign head     = empty ? '0 : mem[rp];
  assign nf_pulse = do_pop && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= push_data;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) begin
        rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  // R5: the count never passes the depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5: a push into a full queue leaves the count as it was
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));

  // R6: a pop of an empty queue leaves it empty
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] lvl_set,
  input  logic [NB-1:0] pls_set,
  input  logic [NB-1:0] st_clr,
  input  logic          en_load,
  input  logic [NB-1:0] en_wdata,
  input  logic [NB-1:0] en_set,
  input  logic [NB-1:0] en_clr,
  output logic [NB-1:0] status,
  output logic [NB-1:0] enable,
  output logic          irq
);

  logic [NB-1:0] status_d, enable_d;

  always_comb begin
    status_d = ((status | lvl_set) & ~st_clr) | pls_set;
    if (en_load) enable_d = en_wdata;
    else         enable_d = (enable | en_set) & ~en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_d;
      enable <= enable_d;
    end
  end

  assign irq = |(status & enable);

  // R9: bits written with 1 read back cleared unless a pulse event set them
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr != '0) |=> ((status & $past(st_clr) & ~$past(pls_set)) == '0));

  // R7: a level event not being cleared shows in status one edge later
  p_newmsg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_set & ~st_clr) != '0) |=>
      ((status & $past(lvl_set & ~st_clr)) == $past(lvl_set & ~st_clr)));

  // R11: set bits become enabled unless cleared in the same write
  p_en_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set & ~en_clr) != '0 && !en_load) |=>
      ((enable & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));

  // R12: a raised line implies both a pending and an enabled bit
  p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0 && enable != '0));

endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int          AW     = 12,
  parameter int          NQ     = 4,
  parameter int          NU     = 2,
  parameter mbx_layout_e LAYOUT = LAYOUT_LEGACY
) (
  input  logic [AW-1:0] addr,
  output logic          sel_rev,
  output logic [NQ-1:0] sel_msg,
  output logic [NQ-1:0] sel_full,
  output logic [NQ-1:0] sel_cnt,
  output logic [NU-1:0] sel_st,
  output logic [NU-1:0] sel_ens,
  output logic [NU-1:0] sel_enc
);

  assign sel_rev = (addr == '0);

  for (genvar m = 0; m < NQ; m++) begin : g_q
    assign sel_msg[m]  = (addr == AW'(64  + 4 * m));
    assign sel_full[m] = (addr == AW'(128 + 4 * m));
    assign sel_cnt[m]  = (addr == AW'(192 + 4 * m));
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    if (LAYOUT == LAYOUT_LEGACY) begin : g_leg
      assign sel_st[u]  = (addr == AW'(256 + 8 * u));
      assign sel_ens[u] = (addr == AW'(260 + 8 * u));
      assign sel_enc[u] = 1'b0;
    end else begin : g_spl
      assign sel_st[u]  = (addr == AW'(260 + 16 * u));
      assign sel_ens[u] = (addr == AW'(264 + 16 * u));
      assign sel_enc[u] = (addr == AW'(268 + 16 * u));
    end
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          NQ       = 4,
  parameter int          NU       = 2,
  parameter int          DEPTH    = 4,
  parameter logic [7:0]  REVISION = 8'h21,
  parameter mbx_layout_e LAYOUT   = LAYOUT_LEGACY,
  localparam int         NB       = 2 * NQ,
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [NU-1:0] irq
);

  logic          wr_fire, rd_fire;
  logic          sel_rev;
  logic [NQ-1:0] sel_msg, sel_full, sel_cnt;
  logic [NU-1:0] sel_st, sel_ens, sel_enc;

  logic [NQ-1:0] q_full, q_empty, q_nfp;
  word_t         q_head [NQ];
  logic [CW-1:0] q_cnt  [NQ];

  logic [NB-1:0] ev_lvl, ev_pls;
  logic [NB-1:0] st_v [NU];
  logic [NB-1:0] en_v [NU];
  word_t         rdata_c;

  assign wr_fire = bus_wr;
  assign rd_fire = bus_rd && !bus_wr;

  mbx_decode #(.AW(AW), .NQ(NQ), .NU(NU), .LAYOUT(LAYOUT)) u_dec (
    .addr     (bus_addr),
    .sel_rev  (sel_rev),
    .sel_msg  (sel_msg),
    .sel_full (sel_full),
    .sel_cnt  (sel_cnt),
    .sel_st   (sel_st),
    .sel_ens  (sel_ens),
    .sel_enc  (sel_enc)
  );

  for (genvar m = 0; m < NQ; m++) begin : g_queue
    mbx_queue #(.DEPTH(DEPTH), .DW(WORD_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_fire && sel_msg[m]),
      .push_data (bus_wdata),
      .pop       (rd_fire && sel_msg[m]),
      .head      (q_head[m]),
      .count     (q_cnt[m]),
      .full      (q_full[m]),
      .empty     (q_empty[m]),
      .nf_pulse  (q_nfp[m])
    );
    assign ev_lvl[2*m]   = !q_empty[m];
    assign ev_lvl[2*m+1] = 1'b0;
    assign ev_pls[2*m]   = 1'b0;
    assign ev_pls[2*m+1] = q_nfp[m];
  end

  for (genvar u = 0; u < NU; u++) begin : g_user
    logic [NB-1:0] st_clr, en_set, en_clr;
    logic          en_load;

    assign st_clr = (wr_fire && sel_st[u]) ? bus_wdata[NB-1:0] : '0;

    if (LAYOUT == LAYOUT_LEGACY) begin : g_leg
      assign en_load = wr_fire && sel_ens[u];
      assign en_set  = '0;
      assign en_clr  = '0;
    end else begin : g_spl
      assign en_load = 1'b0;
      assign en_set  = (wr_fire && sel_ens[u]) ? bus_wdata[NB-1:0] : '0;
      assign en_clr  = (wr_fire && sel_enc[u]) ? bus_wdata[NB-1:0] : '0;
    end

    mbx_user_irq #(.NB(NB)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_set  (ev_lvl),
      .pls_set  (ev_pls),
      .st_clr   (st_clr),
      .en_load  (en_load),
      .en_wdata (bus_wdata[NB-1:0]),
      .en_set   (en_set),
      .en_clr   (en_clr),
      .status   (st_v[u]),
      .enable   (en_v[u]),
      .irq      (irq[u])
    );
  end

  always_comb begin
    rdata_c = '0;
    if (sel_rev) rdata_c = 32'(REVISION);
    for (int m = 0; m < NQ; m++) begin
      if (sel_msg[m])  rdata_c = rdata_c | q_head[m];
      if (sel_full[m]) rdata_c = rdata_c | 32'(q_full[m]);
      if (sel_cnt[m])  rdata_c = rdata_c | 32'(q_cnt[m]);
    end
    for (int u = 0; u < NU; u++) begin
      if (sel_st[u])              rdata_c = rdata_c | 32'(st_v[u]);
      if (sel_ens[u] || sel_enc[u]) rdata_c = rdata_c | 32'(en_v[u]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rdata_c;
    end
  end

  // R2: every accepted read is answered on the next cycle
  p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R2: no response appears without a read
  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);

endmodule

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
  import mbx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_addr = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] b_wdata = '0;
  logic        use_split = 1'b0;

  logic [31:0] rd_l, rd_s;
  logic        rv_l, rv_s;
  logic [1:0]  irq_l, irq_s;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr),
    .bus_wr(b_wr && !use_split), .bus_rd(b_rd && !use_split),
    .bus_wdata(b_wdata), .rd_data(rd_l), .rd_valid(rv_l), .irq(irq_l)
  );

  ipc_mailbox #(.LAYOUT(LAYOUT_SPLIT)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr),
    .bus_wr(b_wr && use_split), .bus_rd(b_rd && use_split),
    .bus_wdata(b_wdata), .rd_data(rd_s), .rd_valid(rv_s), .irq(irq_s)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read response
  always @(negedge clk) begin
    if (rv_l || rv_s) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected response expected=none");
      end else begin
        chk(tag_q.pop_front(), use_split ? rd_s : rd_l, exp_q.pop_front());
      end
    end
  end

  task automatic op_wr(input logic [11:0] a, input logic [31:0] d);
    b_addr = a; b_wdata = d; b_wr = 1'b1; b_rd = 1'b0;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic op_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    b_addr = a; b_rd = 1'b1; b_wr = 1'b0;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", {30'b0, irq_l}, 32'h0);
    chk("R1", {30'b0, irq_s}, 32'h0);
    op_rd(12'h000, 32'h21, "R1");
    op_rd(12'h0C0, 32'h0, "R1");
    op_rd(12'h100, 32'h0, "R1");
    op_rd(12'h104, 32'h0, "R1");
    op_rd(12'h080, 32'h0, "R1");
    // R13 unmapped
    op_rd(12'h004, 32'h0, "R13");
    op_rd(12'h1F0, 32'h0, "R13");
    op_wr(12'h004, 32'hFFFF_FFFF);
    op_rd(12'h000, 32'h21, "R13");
    // R6 pop empty
    op_rd(12'h040, 32'h0, "R6");
    op_rd(12'h0C0, 32'h0, "R6");
    // R2/R3 FIFO on queue 1
    op_wr(12'h044, 32'hA1); op_wr(12'h044, 32'hA2); op_wr(12'h044, 32'hA3);
    idle(1);
    op_rd(12'h0C4, 32'd3, "R3");
    op_rd(12'h084, 32'h0, "R4");
    op_rd(12'h044, 32'hA1, "R2");
    op_rd(12'h044, 32'hA2, "R2");
    op_rd(12'h0C4, 32'd1, "R3");
    // R7 new-message bit 2 for queue 1, both users
    op_rd(12'h100, 32'h4, "R7");
    op_rd(12'h108, 32'h4, "R14");
    chk("R12", {30'b0, irq_l}, 32'h0);
    // R10 legacy enable
    op_wr(12'h104, 32'h4);
    chk("R12", {30'b0, irq_l}, 32'h1);
    op_rd(12'h104, 32'h4, "R10");
    // R9 write-one-to-clear collides with non-empty queue
    op_wr(12'h100, 32'h0);
    op_rd(12'h100, 32'h4, "R9");
    op_wr(12'h100, 32'h4);
    chk("R12", {30'b0, irq_l}, 32'h0);
    op_rd(12'h100, 32'h0, "R9");
    op_rd(12'h100, 32'h4, "R7");
    chk("R12", {30'b0, irq_l}, 32'h1);
    op_rd(12'h044, 32'hA3, "R2");
    idle(1);
    op_wr(12'h100, 32'h4);
    idle(1);
    op_rd(12'h100, 32'h0, "R7");
    chk("R12", {30'b0, irq_l}, 32'h0);
    op_rd(12'h108, 32'h4, "R14");
    // R4/R5 fill queue 2
    for (int i = 0; i < 4; i++) op_wr(12'h048, 32'hD000_0000 + i);
    op_rd(12'h088, 32'h1, "R4");
    op_rd(12'h0C8, 32'd4, "R4");
    op_wr(12'h048, 32'hD000_0004);
    op_rd(12'h0C8, 32'd4, "R5");
    op_rd(12'h100, 32'h10, "R7");
    op_wr(12'h104, 32'h0);
    op_rd(12'h104, 32'h0, "R10");
    op_wr(12'h104, 32'h20);
    chk("R12", {30'b0, irq_l}, 32'h0);
    // R8 pop from full raises not-full bit 5
    op_rd(12'h048, 32'hD000_0000, "R8");
    chk("R8", {30'b0, irq_l}, 32'h1);
    op_rd(12'h100, 32'h30, "R8");
    op_rd(12'h048, 32'hD000_0001, "R5");
    op_rd(12'h048, 32'hD000_0002, "R5");
    op_rd(12'h048, 32'hD000_0003, "R5");
    op_rd(12'h048, 32'h0, "R6");
    op_wr(12'h100, 32'h30);
    idle(1);
    op_rd(12'h100, 32'h0, "R8");
    op_rd(12'h108, 32'h34, "R14");
    idle(2);
    // split layout
    use_split = 1'b1;
    op_rd(12'h000, 32'h21, "R1");
    op_wr(12'h04C, 32'hB0);
    idle(1);
    op_rd(12'h114, 32'h40, "R11");
    op_rd(12'h104, 32'h40, "R11");
    op_rd(12'h100, 32'h0, "R13");
    op_wr(12'h118, 32'h40);
    op_rd(12'h118, 32'h40, "R11");
    chk("R12", {30'b0, irq_s}, 32'h2);
    op_wr(12'h118, 32'h0);
    op_rd(12'h11C, 32'h40, "R11");
    op_wr(12'h11C, 32'h0);
    op_rd(12'h118, 32'h40, "R11");
    op_wr(12'h11C, 32'h40);
    op_rd(12'h118, 32'h0, "R11");
    chk("R12", {30'b0, irq_s}, 32'h0);
    op_wr(12'h114, 32'h40);
    op_rd(12'h114, 32'h0, "R9");
    op_rd(12'h104, 32'h40, "R14");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule